// File: doc/BRIEF.md
# Segment Request Coalescer

This block turns the memory requests of a group of sixteen threads into as few aligned memory transactions as the access pattern allows. A group arrives as one beat: a byte address per thread, a mask of the threads taking part, and an element size code. The block stores the group and then runs in rounds. Each round picks the lowest-numbered thread still waiting. It takes the aligned segment that holds that thread's address. It collects every other waiting thread whose address falls in the same segment. It then narrows the transaction to the smallest aligned half, or quarter, that still covers all the bytes those threads touch.

Each round produces one transaction on a valid/ready output. A transaction carries a base address, a size code and the mask of threads it serves. When the handshake completes, the served threads are retired and the next round starts. A one-cycle done pulse follows the last transaction of a group. A group with no active threads produces the done pulse and no transactions. A thread whose address is not a multiple of its element size is flagged and gets a transaction of its own.

Top module: `seg_coalescer`

## Requirements
- R1: After reset, `txn_valid` and `grp_done` are 0 and `grp_ready` is 1.
- R2: The element size code `grp_esize` selects 1 << code bytes per element (codes 0 to 4; codes above 4 act as 4). The segment is 32 bytes for code 0, 64 bytes for code 1, and 128 bytes for codes 2 to 4. No transaction is larger than its segment.
- R3: Each round is anchored on the lowest-numbered thread still pending. Every other pending, aligned thread whose address lies in the anchor's segment is served by the same transaction, so transactions leave in order of their anchor thread.
- R4: A thread touches the bytes from its address up to its address plus the element size minus one. When all touched bytes of a 128-byte segment lie in one 64-byte half, the transaction is 64 bytes on that half.
- R5: The halving cascades within a round down to 32 bytes, on whichever half is touched. `txn_size` is 0 for 32 bytes, 1 for 64 bytes and 2 for 128 bytes, and `txn_base` is always a multiple of the size.
- R6: Served threads are retired on each handshake, and rounds repeat until none remain. The masks of one group's transactions are disjoint and together equal the active mask.
- R7: While `txn_valid` is high and `txn_ready` is low, the transaction fields hold steady and no round advances.
- R8: `grp_done` is high for exactly one cycle, in the cycle after the last transaction handshake. A group with an all-zero mask raises `grp_done` in the cycle after it is accepted, with no transaction.
- R9: A thread whose address is not a multiple of its element size is never merged with another thread. When it becomes the anchor, it is served alone, with `txn_misalign` set, by a full-segment transaction based at its segment.
- R10: Threads whose mask bit is 0 are never included in any transaction mask, whatever their address.
- R11: A group is taken when `grp_valid` and `grp_ready` are both high. `grp_ready` is low from acceptance until the group's last handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| grp_valid | input | 1 | A request group is offered |
| grp_ready | output | 1 | Block is idle and can take a group |
| grp_esize | input | 3 | Element size code, bytes = 1 << code |
| grp_mask | input | NTHR (16) | Active thread mask |
| grp_addr | input | NTHR*AW (512) | Thread byte addresses, thread k in bits [k*AW +: AW] |
| txn_valid | output | 1 | A transaction is offered |
| txn_ready | input | 1 | Consumer takes the transaction |
| txn_base | output | AW (32) | Transaction base byte address |
| txn_size | output | 2 | 0 = 32 B, 1 = 64 B, 2 = 128 B |
| txn_mask | output | NTHR (16) | Threads served by this transaction |
| txn_misalign | output | 1 | Transaction serves one misaligned thread |
| grp_done | output | 1 | One-cycle pulse after a group is fully served |

## Verification
The assertions take for granted that `grp_esize` and `grp_addr` are only meaningful in the accept cycle. The block captures them then, so later changes on those pins do not matter. The assertions also take for granted that the consumer may hold `txn_ready` low for any number of cycles. The stimulus offers a group only while `grp_ready` is high and drives every address of the group, including those of inactive threads, to defined values. It deliberately places inactive threads and misaligned threads inside the anchor's segment, so that exclusion is visible on `txn_mask`.

// File: rtl/coal_pkg.sv
package coal_pkg;

   typedef enum logic [1:0] {
      SZ_32B  = 2'd0,
      SZ_64B  = 2'd1,
      SZ_128B = 2'd2
   } txn_size_e;

   // log2 of the element size in bytes; codes above 4 clamp to 16 bytes
   function automatic logic [2:0] elem_lg(input logic [2:0] code);
      return (code > 3'd4) ? 3'd4 : code;
   endfunction

   // log2 of the segment size in bytes for a given element size log2
   function automatic logic [2:0] seg_lg(input logic [2:0] elg);
      logic [2:0] r;
      case (elg)
         3'd0:    r = 3'd5;
         3'd1:    r = 3'd6;
         default: r = 3'd7;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/coal_anchor.sv
module coal_anchor #(
   parameter int NTHR = 16,
   localparam int IW = $clog2(NTHR)
) (
   input  logic [NTHR-1:0] pend,
   output logic [NTHR-1:0] anchor_oh,
   output logic [IW-1:0]   anchor_idx
);

   logic [NTHR:0] seen;
   assign seen[0] = 1'b0;

   genvar gi;
   generate
      for (gi = 0; gi < NTHR; gi++) begin : g_pick
         assign anchor_oh[gi] = pend[gi] & ~seen[gi];
         assign seen[gi+1]    = seen[gi] | pend[gi];
      end
   endgenerate

   always_comb begin
      anchor_idx = '0;
      for (int i = 0; i < NTHR; i++) begin
         if (anchor_oh[i]) anchor_idx = anchor_idx | IW'(i);
      end
   end

endmodule

// File: rtl/coal_shrink.sv
module coal_shrink (
   input  logic       en,
   input  logic [2:0] slg,
   input  logic [6:0] lo_off,
   input  logic [6:0] hi_off,
   output logic [2:0] out_lg,
   output logic [6:0] base_off
);

   always_comb begin
      out_lg   = slg;
      base_off = '0;
      if (en) begin
         for (int l = 7; l >= 6; l--) begin
            if ((out_lg == 3'(l)) && (lo_off[l-1] == hi_off[l-1])) begin
               base_off[l-1] = lo_off[l-1];
               out_lg        = 3'(l - 1);
            end
         end
      end
   end

endmodule

// File: rtl/coal_gather.sv
module coal_gather
   import coal_pkg::*;
#(
   parameter int NTHR = 16,
   parameter int AW   = 32
) (
   input  logic [NTHR*AW-1:0] addr,
   input  logic [NTHR-1:0]    pend,
   input  logic [NTHR-1:0]    anchor_oh,
   input  logic [2:0]         esize,
   output logic [NTHR-1:0]    member,
   output logic               misalign,
   output logic [AW-1:0]      base,
   output logic [1:0]         size
);

   logic [2:0]    elg, slg;
   logic [AW-1:0] elem_m, seg_m;
   assign elg    = elem_lg(esize);
   assign slg    = seg_lg(elg);
   assign elem_m = (AW'(1) << elg) - AW'(1);
   assign seg_m  = (AW'(1) << slg) - AW'(1);

   logic [NTHR-1:0] mis;
   logic [7:0]      off_lo [NTHR];
   logic [7:0]      off_hi [NTHR];
   logic [AW-1:0]   segb   [NTHR];

   genvar gi;
   generate
      for (gi = 0; gi < NTHR; gi++) begin : g_thr
         logic [AW-1:0] a;
         assign a           = addr[gi*AW +: AW];
         assign mis[gi]     = |(a & elem_m);
         assign segb[gi]    = a & ~seg_m;
         assign off_lo[gi]  = {1'b0, a[6:0] & seg_m[6:0]};
         assign off_hi[gi]  = off_lo[gi] + elem_m[7:0];
      end
   endgenerate

   logic [AW-1:0] aseg;
   logic          amis;
   always_comb begin
      aseg = '0;
      amis = 1'b0;
      for (int i = 0; i < NTHR; i++) begin
         if (anchor_oh[i]) begin
            aseg = aseg | segb[i];
            amis = amis | mis[i];
         end
      end
   end

   always_comb begin
      for (int i = 0; i < NTHR; i++) begin
         if (amis) member[i] = anchor_oh[i];
         else      member[i] = pend[i] & ~mis[i] & (segb[i] == aseg);
      end
   end

   logic [6:0] lo_min, hi_max;
   always_comb begin
      lo_min = 7'h7f;
      hi_max = 7'h00;
      for (int i = 0; i < NTHR; i++) begin
         if (member[i]) begin
            if (off_lo[i][6:0] < lo_min) lo_min = off_lo[i][6:0];
            if (off_hi[i][6:0] > hi_max) hi_max = off_hi[i][6:0];
         end
      end
   end

   logic [2:0] out_lg;
   logic [6:0] boff;

   coal_shrink u_shrink (
      .en       (~amis),
      .slg      (slg),
      .lo_off   (lo_min),
      .hi_off   (hi_max),
      .out_lg   (out_lg),
      .base_off (boff)
   );

   assign misalign = amis;
   assign base     = aseg | AW'(boff);
   assign size     = 2'(out_lg - 3'd5);

endmodule

// File: rtl/seg_coalescer.sv
module seg_coalescer
   import coal_pkg::*;
#(
   parameter int NTHR = 16,
   parameter int AW   = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 grp_valid,
   output logic                 grp_ready,
   input  logic [2:0]           grp_esize,
   input  logic [NTHR-1:0]      grp_mask,
   input  logic [NTHR*AW-1:0]   grp_addr,
   output logic                 txn_valid,
   input  logic                 txn_ready,
   output logic [AW-1:0]        txn_base,
   output logic [1:0]           txn_size,
   output logic [NTHR-1:0]      txn_mask,
   output logic                 txn_misalign,
   output logic                 grp_done
);

   localparam int IW = $clog2(NTHR);

   generate
      if (NTHR < 2) begin : g_bad_nthr
         $error("seg_coalescer: NTHR must be at least 2");
      end
      if (AW < 8) begin : g_bad_aw
         $error("seg_coalescer: AW must be at least 8");
      end
   endgenerate

   logic                busy_q, done_q;
   logic [NTHR-1:0]     pend_q;
   logic [NTHR*AW-1:0]  addr_q;
   logic [2:0]          esz_q;

   logic [NTHR-1:0]     anchor_oh;
   logic [IW-1:0]       anchor_idx;
   logic [NTHR-1:0]     member;
   logic                accept, fire;
   logic [NTHR-1:0]     pend_nxt;

   coal_anchor #(.NTHR(NTHR)) u_anchor (
      .pend       (pend_q),
      .anchor_oh  (anchor_oh),
      .anchor_idx (anchor_idx)
   );

   coal_gather #(.NTHR(NTHR), .AW(AW)) u_gather (
      .addr      (addr_q),
      .pend      (pend_q),
      .anchor_oh (anchor_oh),
      .esize     (esz_q),
      .member    (member),
      .misalign  (txn_misalign),
      .base      (txn_base),
      .size      (txn_size)
   );

   assign grp_ready = ~busy_q;
   assign accept    = grp_valid & ~busy_q;
   assign txn_valid = busy_q;
   assign txn_mask  = member;
   assign fire      = txn_valid & txn_ready;
   assign pend_nxt  = pend_q & ~member;
   assign grp_done  = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         pend_q <= '0;
         addr_q <= '0;
         esz_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            pend_q <= grp_mask;
            addr_q <= grp_addr;
            esz_q  <= grp_esize;
            busy_q <= |grp_mask;
            done_q <= ~|grp_mask;
         end else if (fire) begin
            pend_q <= pend_nxt;
            if (pend_nxt == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) && $stable(txn_mask)
                                  && $stable(txn_size) && $stable(txn_misalign));

   // R3
   anchor_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> (txn_mask[anchor_idx] && pend_q[anchor_idx]
                     && ((pend_q & ((NTHR'(1) << anchor_idx) - NTHR'(1))) == '0)));

   // R6
   retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> ((pend_q & $past(txn_mask)) == '0));

   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp_done |-> !txn_valid && grp_ready);

   // R11
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> !grp_ready);

   // R9
   misalign_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && txn_misalign |-> $countones(txn_mask) == 1);

   // R5
   base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> ((txn_base & ((AW'(32) << txn_size) - AW'(1))) == '0) && txn_size != 2'd3);

   // R2
   seg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> 3'(txn_size) + 3'd5 <= seg_lg(elem_lg(esz_q)));

   // R10
   inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> (txn_mask & ~pend_q) == '0 && txn_mask != '0);

endmodule

// File: tb/seg_coalescer_tb.sv
module seg_coalescer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NTHR = 16;
   localparam int AW   = 32;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                grp_valid = 1'b0;
   logic                grp_ready;
   logic [2:0]          grp_esize = '0;
   logic [NTHR-1:0]     grp_mask = '0;
   logic [NTHR*AW-1:0]  grp_addr;
   logic                txn_valid;
   logic                txn_ready = 1'b0;
   logic [AW-1:0]       txn_base;
   logic [1:0]          txn_size;
   logic [NTHR-1:0]     txn_mask;
   logic                txn_misalign;
   logic                grp_done;

   logic [AW-1:0] ta [NTHR];
   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int i = 0; i < NTHR; i++) grp_addr[i*AW +: AW] = ta[i];
   end

   seg_coalescer #(.NTHR(NTHR), .AW(AW)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .grp_valid    (grp_valid),
      .grp_ready    (grp_ready),
      .grp_esize    (grp_esize),
      .grp_mask     (grp_mask),
      .grp_addr     (grp_addr),
      .txn_valid    (txn_valid),
      .txn_ready    (txn_ready),
      .txn_base     (txn_base),
      .txn_size     (txn_size),
      .txn_mask     (txn_mask),
      .txn_misalign (txn_misalign),
      .grp_done     (grp_done)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic send_group(input logic [2:0] es, input logic [NTHR-1:0] m);
      @(negedge clk);
      grp_esize = es;
      grp_mask  = m;
      grp_valid = 1'b1;
      @(negedge clk);
      grp_valid = 1'b0;
   endtask

   task automatic expect_txn(input logic [AW-1:0] eb, input logic [1:0] es,
                             input logic [NTHR-1:0] em, input logic ee,
                             input int stall, input string tag);
      int w = 0;
      while (!txn_valid && w < 50) begin
         @(negedge clk);
         w++;
      end
      chk(txn_valid == 1'b1, tag, "txn_valid", 64'(txn_valid), 64'd1);
      for (int s = 0; s < stall; s++) begin
         logic [AW-1:0] b0 = txn_base;
         logic [NTHR-1:0] m0 = txn_mask;
         @(negedge clk);
         chk(txn_valid && txn_base == b0 && txn_mask == m0, "R7", "held under stall",
             {txn_base, txn_mask}, {b0, m0});
      end
      chk(txn_base == eb, tag, "txn_base", 64'(txn_base), 64'(eb));
      chk(txn_size == es, tag, "txn_size", 64'(txn_size), 64'(es));
      chk(txn_mask == em, tag, "txn_mask", 64'(txn_mask), 64'(em));
      chk(txn_misalign == ee, tag, "txn_misalign", 64'(txn_misalign), 64'(ee));
      txn_ready = 1'b1;
      @(negedge clk);
      txn_ready = 1'b0;
   endtask

   task automatic check_done(input string tag);
      chk(grp_done == 1'b1, "R8", {tag, " done pulse"}, 64'(grp_done), 64'd1);
      chk(txn_valid == 1'b0, "R6", {tag, " no txn left"}, 64'(txn_valid), 64'd0);
      @(negedge clk);
      chk(grp_done == 1'b0, "R8", {tag, " done one cycle"}, 64'(grp_done), 64'd0);
   endtask

   // R2 R4: 4-byte elements, contiguous 64 bytes, shrink 128 -> 64
   task automatic t_word_contig();
      for (int k = 0; k < NTHR; k++) ta[k] = 32'h1000 + 32'(4*k);
      send_group(3'd2, 16'hFFFF);
      chk(grp_ready == 1'b0, "R11", "ready low while busy", 64'(grp_ready), 64'd0);
      expect_txn(32'h1000, 2'd1, 16'hFFFF, 1'b0, 0, "R4");
      check_done("word");
   endtask

   // R2: 1-byte elements, 32-byte segment
   task automatic t_byte();
      for (int k = 0; k < NTHR; k++) ta[k] = 32'h2040 + 32'(k);
      send_group(3'd0, 16'hFFFF);
      expect_txn(32'h2040, 2'd0, 16'hFFFF, 1'b0, 0, "R2");
      check_done("byte");
   endtask

   // R2 R5 R6: 2-byte elements across two 64-byte segments
   task automatic t_half_two_seg();
      for (int k = 0; k < 8; k++) ta[k] = 32'h3000 + 32'(2*k);
      for (int k = 8; k < NTHR; k++) ta[k] = 32'h3040 + 32'(2*(k-8));
      send_group(3'd1, 16'hFFFF);
      expect_txn(32'h3000, 2'd0, 16'h00FF, 1'b0, 0, "R5");
      expect_txn(32'h3040, 2'd0, 16'hFF00, 1'b0, 0, "R6");
      check_done("half");
   endtask

   // R10 R6 R7: scattered even threads; odd inactive threads alias thread 0
   task automatic t_scatter();
      for (int k = 0; k < NTHR; k++)
         ta[k] = (k % 2 == 0) ? 32'h4000 + 32'(128*k) : 32'h4000;
      send_group(3'd2, 16'h5555);
      for (int k = 0; k < NTHR; k += 2)
         expect_txn(32'h4000 + 32'(128*k), 2'd0, 16'(1 << k), 1'b0,
                    (k == 0) ? 3 : (k == 4 ? 1 : 0), "R10");
      check_done("scatter");
   endtask

   // R5: cascade to the upper quarter; R2: 16-byte elements keep 128
   task automatic t_upper_and_full();
      ta[0] = 32'h5070; ta[1] = 32'h5078; ta[2] = 32'h5060; ta[3] = 32'h5068;
      for (int k = 4; k < NTHR; k++) ta[k] = 32'h0;
      send_group(3'd3, 16'h000F);
      expect_txn(32'h5060, 2'd0, 16'h000F, 1'b0, 0, "R5");
      check_done("upper");
      ta[0] = 32'h6000; ta[1] = 32'h6070;
      send_group(3'd4, 16'h0003);
      expect_txn(32'h6000, 2'd2, 16'h0003, 1'b0, 0, "R2");
      check_done("full");
   endtask

   // R3: anchor is lowest active thread, gathers a high thread
   task automatic t_anchor_order();
      for (int k = 0; k < NTHR; k++) ta[k] = 32'h7100;
      ta[1] = 32'h7100; ta[2] = 32'h7000; ta[15] = 32'h7104;
      send_group(3'd2, 16'h8006);
      expect_txn(32'h7100, 2'd0, 16'h8002, 1'b0, 0, "R3");
      expect_txn(32'h7000, 2'd0, 16'h0004, 1'b0, 0, "R3");
      check_done("anchor");
   endtask

   // R9: misaligned anchor and misaligned non-anchor
   task automatic t_misalign();
      ta[0] = 32'h8002; ta[1] = 32'h8004; ta[2] = 32'h8008; ta[3] = 32'h8011;
      send_group(3'd2, 16'h000F);
      expect_txn(32'h8000, 2'd2, 16'h0001, 1'b1, 0, "R9");
      expect_txn(32'h8000, 2'd0, 16'h0006, 1'b0, 0, "R9");
      expect_txn(32'h8000, 2'd2, 16'h0008, 1'b1, 0, "R9");
      check_done("misalign");
   endtask

   // R8: empty mask gives done and nothing else
   task automatic t_empty();
      send_group(3'd2, 16'h0000);
      chk(txn_valid == 1'b0, "R8", "empty no txn", 64'(txn_valid), 64'd0);
      check_done("empty");
      chk(grp_ready == 1'b1, "R11", "ready after empty", 64'(grp_ready), 64'd1);
   endtask

   initial begin
      for (int k = 0; k < NTHR; k++) ta[k] = '0;
      repeat (3) @(negedge clk);
      // R1
      chk(txn_valid == 1'b0, "R1", "reset txn_valid", 64'(txn_valid), 64'd0);
      chk(grp_done == 1'b0, "R1", "reset grp_done", 64'(grp_done), 64'd0);
      chk(grp_ready == 1'b1, "R1", "reset grp_ready", 64'(grp_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      t_word_contig();
      t_byte();
      t_half_two_seg();
      t_scatter();
      t_upper_and_full();
      t_anchor_order();
      t_misalign();
      t_empty();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL R6 watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule